// File: doc/BRIEF.md
# Byte-Addressed Data Memory Port

This block is the data-side access unit of a small core. It owns a byte-addressed storage array and serves two access sizes: full 32-bit words and single bytes. A load returns a 32-bit result combinationally from the array. A byte load places the chosen byte in the low eight bits and copies its top bit into the upper 24. A store is committed on the rising clock edge and is controlled by four per-lane write enables. These enables are also driven out as ports.

Inside a word, the byte at the lowest address occupies bits 31:24 and the byte at the highest address occupies bits 7:0. Word element i of an array based at byte address B therefore lives at B + 4*i. A word access whose two low address bits are not both zero is flagged as misaligned. Such an access writes nothing, and a load of this kind returns zero. An active-low asynchronous reset clears the whole array.

Top module: `dmem_port`

## Requirements
- R1: While and after reset (rstN low), every byte of the array reads as zero.
- R2: An aligned word store (accSize=1, storeStb=1, addr[1:0]=0) drives byteWe=4'b1111. From the next rising edge, a word load of that address returns the store data exactly.
- R3: Byte lanes run in address order from the top of the word: address offset o (addr[1:0]) maps to load data bits 31-8*o down to 24-8*o. This lane is enabled by byteWe bit 3-o.
- R4: A byte load (accSize=0, loadStb=1) returns the addressed byte in bits 7:0, with bits 31:8 all equal to bit 7 of that byte.
- R5: A byte store drives exactly one write enable, byteWe = 4'b0001 << (3-addr[1:0]). It writes only storeData[7:0] into the addressed byte and leaves the other three bytes of the word unchanged.
- R6: A word load or store with addr[1:0] nonzero raises alignErr and drives byteWe=0. It changes no byte of the array, and a load of this kind returns zero.
- R7: Byte accesses never raise alignErr, whatever the value of addr[1:0].
- R8: With loadStb and storeStb both low, loadData, byteWe and alignErr are all zero.
- R9: When a load and a store hit the same address in one cycle, the load returns the contents from before the write. The new value is visible from the next cycle.
- R10: Distinct word indices address distinct storage, including the first and the last word of the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears the array |
| addr | input | ADDR_W | Byte address (ADDR_W = log2(4*DEPTH_WORDS)) |
| storeData | input | 32 | Data to store; a byte store uses bits 7:0 |
| accSize | input | 1 | Access size: 0 = byte, 1 = word |
| loadStb | input | 1 | Load request |
| storeStb | input | 1 | Store request |
| loadData | output | 32 | Load result, combinational from the array |
| byteWe | output | 4 | Per-lane write enables; bit 3 is the lowest-address byte |
| alignErr | output | 1 | Misaligned word access flag |

## Verification
A load and a store can fall in the same cycle. The case that matters is when both target one word. To provoke it, the bench raises both strobes with a word access at an address that already holds known data. The combinational load result is sampled before the clock edge and must equal the old contents. A plain load one cycle later must return the new data. Misalignment is also exercised in the same-cycle setting: a misaligned word store must leave the previously written word intact, and byte stores at every offset must raise no error.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int LSEL_W = $clog2(LANES);

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic              readEn;
    logic              wordAcc;
    logic [LANES-1:0]  laneWe;
    logic [LSEL_W-1:0] laneSel;
  } dmem_strobe_t;
endpackage

// File: rtl/dmem_ctrl.sv
module dmem_ctrl
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              accSize,
  input  logic              loadStb,
  input  logic              storeStb,
  output dmem_strobe_t      strobe,
  output logic              alignErr
);
  acc_size_e         sizeSel;
  logic              anyStb;
  logic              misaligned;
  logic [LSEL_W-1:0] offset;
  logic [LSEL_W-1:0] lane;

  assign sizeSel    = acc_size_e'(accSize);
  assign anyStb     = loadStb | storeStb;
  assign offset     = addr[LSEL_W-1:0];
  // lowest address sits in the most significant lane
  assign lane       = LSEL_W'(LANES - 1) - offset;
  assign misaligned = (sizeSel == SZ_WORD) && (offset != '0) && anyStb;

  always_comb begin
    strobe         = '0;
    strobe.wordAcc = (sizeSel == SZ_WORD);
    strobe.laneSel = lane;
    strobe.readEn  = loadStb && !misaligned;
    if (storeStb && !misaligned) begin
      if (sizeSel == SZ_WORD) strobe.laneWe = '1;
      else                    strobe.laneWe = LANES'(1) << lane;
    end
  end

  assign alignErr = misaligned;
endmodule

// File: rtl/dmem_datapath.sv
module dmem_datapath
  import dmem_pkg::*;
#(
  parameter int DEPTH_WORDS = 16,
  parameter int ADDR_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] storeData,
  input  dmem_strobe_t      strobe,
  output logic [WORD_W-1:0] loadData
);
  localparam int WIDX_W = ADDR_W - LSEL_W;

  logic [BYTE_W-1:0] memArr [DEPTH_WORDS][LANES];
  logic [WIDX_W-1:0] wIdx;
  logic [BYTE_W-1:0] laneIn [LANES];
  logic [WORD_W-1:0] rdWord;
  logic [BYTE_W-1:0] selByte;

  assign wIdx = addr[ADDR_W-1:LSEL_W];

  // lane steering: word store takes its own slice, byte store the low byte
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIn[l] = strobe.wordAcc ? storeData[l*BYTE_W +: BYTE_W]
                                      : storeData[BYTE_W-1:0];
    assign rdWord[l*BYTE_W +: BYTE_W] = memArr[wIdx][l];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH_WORDS; w++)
        for (int l = 0; l < LANES; l++)
          memArr[w][l] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (strobe.laneWe[l]) memArr[wIdx][l] <= laneIn[l];
    end
  end

  assign selByte = memArr[wIdx][strobe.laneSel];

  always_comb begin
    if (!strobe.readEn)      loadData = '0;
    else if (strobe.wordAcc) loadData = rdWord;
    else                     loadData = {{(WORD_W-BYTE_W){selByte[BYTE_W-1]}}, selByte};
  end

  // R9: no write last cycle and same word read twice -> result unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.laneWe) == '0 && $past(strobe.readEn) && $past(strobe.wordAcc)
     && strobe.readEn && strobe.wordAcc && $past(wIdx) == wIdx)
    |-> loadData == $past(loadData));

  // R2: full-word write is readable from the next cycle
  p_word_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.laneWe) == '1 && strobe.readEn && strobe.wordAcc
     && $past(wIdx) == wIdx && $past(strobe.wordAcc))
    |-> loadData == $past(storeData));
endmodule

// File: rtl/dmem_port.sv
module dmem_port
  import dmem_pkg::*;
#(
  parameter  int DEPTH_WORDS = 16,
  localparam int ADDR_W      = $clog2(4 * DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       storeData,
  input  logic              accSize,
  input  logic              loadStb,
  input  logic              storeStb,
  output logic [31:0]       loadData,
  output logic [3:0]        byteWe,
  output logic              alignErr
);
  dmem_strobe_t strobe;

  dmem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr     (addr),
    .accSize  (accSize),
    .loadStb  (loadStb),
    .storeStb (storeStb),
    .strobe   (strobe),
    .alignErr (alignErr)
  );

  dmem_datapath #(.DEPTH_WORDS(DEPTH_WORDS), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .storeData (storeData),
    .strobe    (strobe),
    .loadData  (loadData)
  );

  assign byteWe = strobe.laneWe;

  p_misalign_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accSize && addr[1:0] != 2'b00 && (loadStb || storeStb))
    |-> (alignErr && byteWe == 4'b0000 && loadData == 32'h0));

  p_byte_noerr_r7: assert property (@(posedge clk) disable iff (!rstN)
    !accSize |-> !alignErr);

  p_byte_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!accSize && storeStb) |-> $countones(byteWe) == 1);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !storeStb) |-> (loadData == 32'h0 && byteWe == 4'b0000 && !alignErr));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!accSize && loadStb) |-> loadData[31:8] == {24{loadData[7]}});
endmodule

// File: tb/tb_dmem_port.sv
module tb_dmem_port;
  localparam int DEPTH_WORDS = 16;
  localparam int ADDR_W      = $clog2(4 * DEPTH_WORDS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       storeData = '0;
  logic              accSize = 1'b0;
  logic              loadStb = 1'b0;
  logic              storeStb = 1'b0;
  logic [31:0]       loadData;
  logic [3:0]        byteWe;
  logic              alignErr;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  dmem_port #(.DEPTH_WORDS(DEPTH_WORDS)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .storeData(storeData),
    .accSize(accSize), .loadStb(loadStb), .storeStb(storeStb),
    .loadData(loadData), .byteWe(byteWe), .alignErr(alignErr)
  );

  typedef struct packed {
    logic              word;
    logic              ld;
    logic              st;
    logic [ADDR_W-1:0] a;
    logic [31:0]       wd;
    logic [31:0]       expData;
    logic [3:0]        expWe;
    logic              expErr;
    logic [7:0]        rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0, 6'd0,  32'h0,        32'h0,        4'h0, 1'b0, 8'd1 },  // R1
    '{1'b1,1'b0,1'b1, 6'd4,  32'h11223344, 32'h0,        4'hF, 1'b0, 8'd2 },  // R2
    '{1'b1,1'b1,1'b0, 6'd4,  32'h0,        32'h11223344, 4'h0, 1'b0, 8'd2 },  // R2
    '{1'b0,1'b1,1'b0, 6'd4,  32'h0,        32'h00000011, 4'h0, 1'b0, 8'd3 },  // R3
    '{1'b0,1'b1,1'b0, 6'd7,  32'h0,        32'h00000044, 4'h0, 1'b0, 8'd3 },  // R3
    '{1'b1,1'b0,1'b1, 6'd8,  32'h80FF7F01, 32'h0,        4'hF, 1'b0, 8'd10},  // R10
    '{0,1,0,          6'd8,  32'h0,        32'hFFFFFF80, 4'h0, 1'b0, 8'd4 },  // R4
    '{0,1,0,          6'd9,  32'h0,        32'hFFFFFFFF, 4'h0, 1'b0, 8'd4 },  // R4
    '{0,1,0,          6'd10, 32'h0,        32'h0000007F, 4'h0, 1'b0, 8'd4 },  // R4
    '{0,0,1,          6'd5,  32'hABCDEFAA, 32'h0,        4'h4, 1'b0, 8'd5 },  // R5
    '{1,1,0,          6'd4,  32'h0,        32'h11AA3344, 4'h0, 1'b0, 8'd5 },  // R5
    '{1,0,1,          6'd6,  32'hDEADBEEF, 32'h0,        4'h0, 1'b1, 8'd6 },  // R6
    '{1,1,0,          6'd4,  32'h0,        32'h11AA3344, 4'h0, 1'b0, 8'd6 },  // R6
    '{1,1,0,          6'd13, 32'h0,        32'h0,        4'h0, 1'b1, 8'd6 },  // R6
    '{1,1,1,          6'd9,  32'h12345678, 32'h0,        4'h0, 1'b1, 8'd6 },  // R6
    '{0,1,0,          6'd11, 32'h0,        32'h00000001, 4'h0, 1'b0, 8'd7 },  // R7
    '{0,0,1,          6'd63, 32'hFFFFFF5A, 32'h0,        4'h1, 1'b0, 8'd7 },  // R7
    '{1,0,0,          6'd4,  32'hFFFFFFFF, 32'h0,        4'h0, 1'b0, 8'd8 },  // R8
    '{1,1,1,          6'd4,  32'hCAFEF00D, 32'h11AA3344, 4'hF, 1'b0, 8'd9 },  // R9
    '{1,1,0,          6'd4,  32'h0,        32'hCAFEF00D, 4'h0, 1'b0, 8'd9 },  // R9
    '{1,1,0,          6'd60, 32'h0,        32'h0000005A, 4'h0, 1'b0, 8'd10},  // R10
    '{1,0,1,          6'd0,  32'h0BADF00D, 32'h0,        4'hF, 1'b0, 8'd10},  // R10
    '{1,1,0,          6'd0,  32'h0,        32'h0BADF00D, 4'h0, 1'b0, 8'd10},  // R10
    '{1,1,0,          6'd8,  32'h0,        32'h80FF7F01, 4'h0, 1'b0, 8'd10}   // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic l, input logic s,
                       input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    accSize = w; loadStb = l; storeStb = s; addr = a; storeData = d;
    #1;
  endtask

  initial begin : watchdog
    #500000;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, outputs while idle in reset
    #1;
    check("R1 idle loadData in reset", loadData, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].word, VEC[i].ld, VEC[i].st, VEC[i].a, VEC[i].wd);
      check($sformatf("R%0d vec%0d loadData", VEC[i].rq, i), loadData, VEC[i].expData);
      check($sformatf("R%0d vec%0d byteWe", VEC[i].rq, i), {28'h0, byteWe}, {28'h0, VEC[i].expWe});
      check($sformatf("R%0d vec%0d alignErr", VEC[i].rq, i), {31'h0, alignErr}, {31'h0, VEC[i].expErr});
    end

    // R5: byte stores at every offset, each touching only its own byte
    for (int o = 0; o < 4; o++) begin
      drive(1'b0, 1'b0, 1'b1, ADDR_W'(12 + o), 32'h00000010 + o);
      check("R5 one-hot enable", {28'h0, byteWe}, {28'h0, 4'b0001 << (3 - o)});
    end
    drive(1'b1, 1'b1, 1'b0, ADDR_W'(12), 32'h0);
    check("R5 assembled word", loadData, 32'h10111213);

    // R1: reset mid-run clears written data
    @(negedge clk);
    rstN = 1'b0;
    accSize = 1'b1; loadStb = 1'b1; storeStb = 1'b0; addr = ADDR_W'(4);
    #1;
    check("R1 word cleared by reset", loadData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b0, ADDR_W'(60), 32'h0);
    check("R1 last word cleared", loadData, 32'h0);
    drive(1'b0, 1'b0, 1'b0, '0, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule